// File: doc/BRIEF.md
# Programmable 14-bit Interval Timer

This block is a 14-bit down counter that a processor sets up through two byte-wide register slots. One slot takes the low eight bits of the count length. The other takes the upper six bits and two mode bits. The counter advances only in system-clock cycles in which a timer-input enable pulse is present. This lets a slower reference, such as a 1.2288 MHz source, set the rate: a length of 1024 gives 1200 terminal counts per second, and a length of 16384 gives 75.

A two-bit command starts or stops the counter. The command comes from a command register shared with other logic. Its field decode belongs to that logic, and this block receives only the strobe and the code. Start and stop requests issued while the counter runs can be deferred to the next terminal count. A start while running therefore changes length and mode without breaking the current period. A stop-after-terminal-count request lets the last period finish cleanly.

At each terminal count the block emits a one-cycle event strobe for the status logic. Its output pin then either pulses or forms a square wave, as the mode selects. Reads return the live count and the active mode, not the programmed length.

Top module: `interval_timer14`

## Requirements
- R1: After reset the live count reads 0, the mode reads 00, the counter is stopped, and `timer_out` and `tc_event` are low.
- R2: A write with `wr_sel`=0 sets length bits 7:0 from `wr_data`. A write with `wr_sel`=1 sets length bits 13:8 from `wr_data[5:0]` and the mode from `wr_data[7:6]`. Writes do not alter the live count or the active mode.
- R3: Command code 11 (start) on a stopped timer loads the live count, active length and active mode from the programmed values in the same cycle. While running, the count drops by one only in cycles where `tick` is high.
- R4: With `rd_sel`=0, `rd_data` shows live count bits 7:0. With `rd_sel`=1 it shows the active mode in bits 7:6 and live count bits 13:8 in bits 5:0.
- R5: A tick while the count is 1 is a terminal count. `tc_event` is high for exactly the following cycle, and the count reloads the active length. With mode bit 7 (auto reload) set the timer keeps running; with it clear the timer stops.
- R6: With mode bit 6 set (square wave), `timer_out` is high while running and the count exceeds half the length (rounded down), and low otherwise.
- R7: With mode bit 6 clear (pulse), `timer_out` is high exactly in the cycle `tc_event` is high.
- R8: Command 01 (halt) stops a running timer at once. The count holds, and a tick in the same cycle is ignored. On a stopped timer the command has no effect.
- R9: Command 10 (halt at terminal count) lets the counter run to its next terminal count and then stops it. On a stopped timer the command has no effect.
- R10: Command 11 on a running timer does not disturb the current count. The programmed length and mode take over at the next terminal count, and the timer keeps running.
- R11: A programmed length of 0 or 1 is used as 2.
- R12: Command 00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-input enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write slot: 0 low length byte, 1 high bits and mode |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read slot: 0 low count byte, 1 mode and high count bits |
| rd_data | output | 8 | Live count and mode read value |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | Command code: 00 none, 01 halt, 10 halt at terminal count, 11 start |
| timer_out | output | 1 | Shaped timer output |
| tc_event | output | 1 | One-cycle terminal-count strobe |

## Verification
The bench goes after the deferred commands.
- A start issued mid-count must keep the old mode visible until the terminal count. A design that reloads at once would show the new length early.
- A halt-at-terminal-count must still let the in-flight tick decrement. A design that treats it as an immediate halt would freeze the count one step early.
- A halt arriving with a tick must freeze the count. An off-by-one in ordering here shows up as a decremented value.
- A length of 1 must behave as 2. Without the clamp the first tick would raise the terminal count.
- An odd square-wave length must put the extra tick in the high half.
- A 256-length auto-reload run must give exactly four events in 1024 ticks.

// File: rtl/timer14_pkg.sv
package timer14_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_HALT    = 2'b01,
        CMD_HALT_TC = 2'b10,
        CMD_LAUNCH  = 2'b11
    } tcmd_e;

    // positions inside the two-bit mode field
    localparam int MODE_SQUARE = 0;
    localparam int MODE_AUTO   = 1;
    localparam int MODE_W      = 2;
    localparam int BYTE_W      = 8;

endpackage

// File: rtl/t14_length_reg.sv
module t14_length_reg
    import timer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [CNT_W-1:0]     len_o,
    output logic [MODE_W-1:0]    mode_o
);
    localparam int HI_W = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0]  len;
        logic [MODE_W-1:0] mode;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (!wr_sel) begin
                s_d.len[BYTE_W-1:0] = wr_data;
            end else begin
                s_d.len[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
                s_d.mode = wr_data[BYTE_W-1 -: MODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign len_o  = (s_q.len < MIN_LEN) ? MIN_LEN : s_q.len;
    assign mode_o = s_q.mode;

endmodule

// File: rtl/t14_count_core.sv
module t14_count_core
    import timer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd,
    input  logic [CNT_W-1:0]     new_len,
    input  logic [MODE_W-1:0]    new_mode,
    output logic [CNT_W-1:0]     count_o,
    output logic [CNT_W-1:0]     len_o,
    output logic [MODE_W-1:0]    mode_o,
    output logic                 running_o,
    output logic                 tc_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic              running;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  len;
        logic [MODE_W-1:0] mode;
        logic              pend_launch;
        logic              pend_halt;
        logic              tc;
    } core_t;

    core_t s_d, s_q;
    tcmd_e op;

    always_comb begin
        op = cmd_valid ? tcmd_e'(cmd) : CMD_NONE;
        s_d = s_q;
        s_d.tc = 1'b0;
        if (!s_q.running) begin
            if (op == CMD_LAUNCH) begin
                s_d.running     = 1'b1;
                s_d.count       = new_len;
                s_d.len         = new_len;
                s_d.mode        = new_mode;
                s_d.pend_launch = 1'b0;
                s_d.pend_halt   = 1'b0;
            end
        end else begin
            unique case (op)
                CMD_HALT: begin
                    s_d.running     = 1'b0;
                    s_d.pend_launch = 1'b0;
                    s_d.pend_halt   = 1'b0;
                end
                CMD_HALT_TC: begin
                    s_d.pend_halt   = 1'b1;
                    s_d.pend_launch = 1'b0;
                end
                CMD_LAUNCH: begin
                    s_d.pend_launch = 1'b1;
                    s_d.pend_halt   = 1'b0;
                end
                default: ;
            endcase
            if (tick && op != CMD_HALT) begin
                if (s_q.count <= ONE) begin
                    s_d.tc = 1'b1;
                    if (s_d.pend_launch) begin
                        s_d.len   = new_len;
                        s_d.mode  = new_mode;
                        s_d.count = new_len;
                    end else begin
                        s_d.count = s_q.len;
                        if (s_d.pend_halt || !s_q.mode[MODE_AUTO])
                            s_d.running = 1'b0;
                    end
                    s_d.pend_launch = 1'b0;
                    s_d.pend_halt   = 1'b0;
                end else begin
                    s_d.count = s_q.count - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o   = s_q.count;
    assign len_o     = s_q.len;
    assign mode_o    = s_q.mode;
    assign running_o = s_q.running;
    assign tc_o      = s_q.tc;

endmodule

// File: rtl/t14_out_shaper.sv
module t14_out_shaper
    import timer14_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 running,
    input  logic [MODE_W-1:0]    mode,
    input  logic [CNT_W-1:0]     count,
    input  logic [CNT_W-1:0]     len,
    input  logic                 tc,
    output logic                 out_o
);
    logic [CNT_W-1:0] half;
    logic             wave;

    always_comb begin
        half = len >> 1;
        if (mode[MODE_SQUARE]) wave = running && (count > half);
        else                   wave = tc;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic out_d, out_q;
            assign out_d = wave;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= 1'b0;
                else        out_q <= out_d;
            end
            assign out_o = out_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign out_o = wave;
        end
    endgenerate

endmodule

// File: rtl/interval_timer14.sv
module interval_timer14
    import timer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        rd_sel,
    output logic [7:0]  rd_data,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd,
    output logic        timer_out,
    output logic        tc_event
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic [CNT_W-1:0]  prog_len;
    logic [MODE_W-1:0] prog_mode;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  act_len;
    logic [MODE_W-1:0] act_mode;
    logic              run_w;
    logic              tc_w;
    logic [7:0]        hi_byte;

    t14_length_reg #(.CNT_W(CNT_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .len_o   (prog_len),
        .mode_o  (prog_mode)
    );

    t14_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .new_len   (prog_len),
        .new_mode  (prog_mode),
        .count_o   (cnt_w),
        .len_o     (act_len),
        .mode_o    (act_mode),
        .running_o (run_w),
        .tc_o      (tc_w)
    );

    t14_out_shaper #(.CNT_W(CNT_W), .REG_OUT(1'b0)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (run_w),
        .mode    (act_mode),
        .count   (cnt_w),
        .len     (act_len),
        .tc      (tc_w),
        .out_o   (timer_out)
    );

    always_comb begin
        hi_byte = '0;
        hi_byte[HI_W-1:0] = cnt_w[CNT_W-1:BYTE_W];
        hi_byte[BYTE_W-1 -: MODE_W] = act_mode;
    end

    assign rd_data  = rd_sel ? hi_byte : cnt_w[BYTE_W-1:0];
    assign tc_event = tc_w;

endmodule

// File: rtl/t14_checker.sv
module t14_checker #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cmd_valid,
    input logic [1:0]       cmd,
    input logic             tc_event,
    input logic             running,
    input logic [CNT_W-1:0] count
);
    // R3: no tick and no command leaves a running count untouched
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !cmd_valid) |=> $stable(count));

    // R5: the event strobe follows a tick taken at count 1
    p_tc_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_event |-> $past(running && tick && count == CNT_W'(1)));

    // R5: the strobe never lasts two cycles
    p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_event |=> !tc_event);

    // R8: halt on a running timer freezes it at once
    p_halt_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmd_valid && cmd == 2'b01) |=> (!running && $stable(count)));

    // R9: anything but start on a stopped timer changes nothing
    p_idle_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && cmd_valid && cmd != 2'b11) |=> (!running && $stable(count)));

    // R11: a running count never reaches zero
    p_count_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count != '0));

endmodule

bind interval_timer14 t14_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .tc_event  (tc_event),
    .running   (run_w),
    .count     (cnt_w)
);

// File: tb/sim_interval_timer14.sv
module sim_interval_timer14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = '0;
    logic       timer_out;
    logic       tc_event;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    interval_timer14 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd(cmd), .timer_out(timer_out), .tc_event(tc_event)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic cv, input logic [1:0] c);
        tick = tk; cmd_valid = cv; cmd = c;
        @(negedge clk);
        tick = 1'b0; cmd_valid = 1'b0; cmd = 2'b00;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk("R1 count low", v, 0);
        rd(1'b1, v); chk("R1 mode/high", v, 0);
        chk("R1 out", timer_out, 0);
        chk("R1 tc", tc_event, 0);
    endtask

    task automatic t_square_auto;
        logic [7:0] v;
        wr(1'b0, 8'h06);
        wr(1'b1, 8'hC0);
        rd(1'b0, v); chk("R2 write not live", v, 0);
        cyc(1'b0, 1'b1, 2'b11);
        rd(1'b0, v); chk("R3 loaded", v, 6);
        rd(1'b1, v); chk("R4 mode bits", v, 8'hC0);
        chk("R6 high start", timer_out, 1);
        cyc(1'b1, 1'b0, 2'b00);
        cyc(1'b1, 1'b0, 2'b00);
        rd(1'b0, v); chk("R3 after 2 ticks", v, 4);
        chk("R6 high at 4", timer_out, 1);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R6 low at half", timer_out, 0);
        cyc(1'b0, 1'b0, 2'b00);
        rd(1'b0, v); chk("R3 no tick hold", v, 3);
        cyc(1'b0, 1'b0, 2'b00);
        cyc(1'b1, 1'b0, 2'b00);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R5 no early tc", tc_event, 0);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R5 tc", tc_event, 1);
        rd(1'b0, v); chk("R5 reload", v, 6);
        chk("R6 high after reload", timer_out, 1);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R5 tc one cycle", tc_event, 0);
        cyc(1'b1, 1'b1, 2'b00);
        rd(1'b0, v); chk("R12 nop keeps counting", v, 4);
        cyc(1'b1, 1'b1, 2'b01);
        rd(1'b0, v); chk("R8 halt ignores tick", v, 4);
        chk("R8 out low", timer_out, 0);
        cyc(1'b1, 1'b0, 2'b00);
        rd(1'b0, v); chk("R8 stays halted", v, 4);
        cyc(1'b1, 1'b1, 2'b01);
        cyc(1'b1, 1'b1, 2'b00);
        rd(1'b0, v); chk("R8 halt idle no effect", v, 4);
        rd(1'b1, v); chk("R12 mode kept", v, 8'hC0);
    endtask

    task automatic t_pulse_oneshot;
        logic [7:0] v;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h00);
        cyc(1'b0, 1'b1, 2'b11);
        rd(1'b0, v); chk("R11 min length", v, 2);
        chk("R7 out idle low", timer_out, 0);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R11 no tc at first tick", tc_event, 0);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R5 tc oneshot", tc_event, 1);
        chk("R7 pulse with tc", timer_out, 1);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R7 pulse ends", timer_out, 0);
        rd(1'b0, v); chk("R5 oneshot stopped", v, 2);
    endtask

    task automatic t_halt_at_tc;
        logic [7:0] v;
        cyc(1'b1, 1'b1, 2'b10);
        cyc(1'b1, 1'b0, 2'b00);
        rd(1'b0, v); chk("R9 idle no effect", v, 2);
        wr(1'b0, 8'h03);
        wr(1'b1, 8'hC0);
        cyc(1'b0, 1'b1, 2'b11);
        cyc(1'b1, 1'b0, 2'b00);
        cyc(1'b1, 1'b1, 2'b10);
        rd(1'b0, v); chk("R9 keeps counting", v, 1);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R9 tc reached", tc_event, 1);
        cyc(1'b1, 1'b0, 2'b00);
        rd(1'b0, v); chk("R9 stopped after tc", v, 3);
        chk("R9 out low when stopped", timer_out, 0);
    endtask

    task automatic t_relaunch;
        logic [7:0] v;
        wr(1'b0, 8'h04);
        wr(1'b1, 8'hC0);
        cyc(1'b0, 1'b1, 2'b11);
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h40);
        rd(1'b0, v); chk("R2 write while running", v, 4);
        cyc(1'b1, 1'b0, 2'b00);
        cyc(1'b1, 1'b0, 2'b00);
        cyc(1'b1, 1'b1, 2'b11);
        rd(1'b0, v); chk("R10 count undisturbed", v, 1);
        rd(1'b1, v); chk("R10 old mode until tc", v, 8'hC0);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R10 tc", tc_event, 1);
        rd(1'b0, v); chk("R10 new length", v, 8);
        rd(1'b1, v); chk("R10 new mode", v, 8'h40);
        chk("R6 square high new", timer_out, 1);
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 2'b00);
        chk("R6 square low at 1", timer_out, 0);
        cyc(1'b1, 1'b0, 2'b00);
        chk("R5 tc new length", tc_event, 1);
        cyc(1'b1, 1'b0, 2'b00);
        rd(1'b0, v); chk("R5 oneshot after relaunch", v, 8);
    endtask

    task automatic t_long_rate;
        logic [7:0] v;
        int n = 0;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h81);
        cyc(1'b0, 1'b1, 2'b11);
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b1, 1'b0, 2'b00);
            if (tc_event) n++;
        end
        chk("R5 events in 1024 ticks", n, 4);
        cyc(1'b0, 1'b1, 2'b01);
        rd(1'b0, v); chk("R4 low byte 256", v, 0);
        rd(1'b1, v); chk("R4 high byte 256", v, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_square_auto();
        t_pulse_oneshot();
        t_halt_at_tc();
        t_relaunch();
        t_long_rate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule